// File: doc/BRIEF.md
# Serial ADC Word Alignment Trainer

This block sits behind the double-edge capture stage of a single-lane serial ADC link. Each cycle of the divided data clock delivers four captured bits as a nibble. The block puts them back into serial order, keeps a 24-bit history of the stream, and cuts 12-bit sample words out of that history. Samples travel most significant bit first.

The word boundary is not known at power-up. It is learned from the converter itself. Software puts the converter into its sync test mode and pulses the train request. While the converter repeats the pattern 111111000000, the block tests all twelve bit offsets on every frame. It locks only when one offset has matched on eight frames in a row. After lock, the offset is frozen and one aligned word with a valid strobe comes out per frame. The converter can then return to normal offset-binary sampling. If no offset matches within a fixed number of cycles after the request, an error flag is raised.

Top module: `adc_word_aligner`

## Requirements
- R1: During and straight after reset, `word_o` is all zeros and `valid_o`, `locked_o`, `err_o` and `off_o` are 0.
- R2: Within a nibble, serial bits arrive first in `nib_i[0]`, then `nib_i[2]`, then `nib_i[1]`, then `nib_i[3]`. A word is 12 consecutive serial bits with the earliest bit in `word_o[11]`. When locked onto the sync stream, every word presented is 12'hFC0.
- R3: A frame closes after each data-clock cycle in which the nibble count since reset is 2 mod 3. At that point the last received serial bit has stream index 12m+7. The reported offset k is the number of bits received after the last bit of the matching word. A sync stream whose bit i equals pattern bit ((i+s) mod 12), counted from the MSB, therefore yields k = (s+8) mod 12 for every s from 0 to 11.
- R4: Lock is declared at the edge that follows the eighth consecutive frame whose match has the same offset. A frame with no match restarts the count. With a clean stream, `locked_o` rises 22 to 24 edges after the edge that samples the train request.
- R5: Once locked, `off_o` and the word slicing stay fixed, whatever the stream carries, until reset or a new train request.
- R6: While locked, `valid_o` is high for exactly one cycle per frame, on the edge after the frame closes. `word_o` then holds the 12 bits that end k bits before the newest bit received at that frame.
- R7: `err_o` rises exactly 256 edges after the request edge if no frame has matched since the request. A new train request clears it, and so does lock.
- R8: A train request has priority. If it is sampled on a frame-closing cycle while locked, no valid is produced, and lock drops at that same edge.
- R9: After reset and before any train request, the block never locks and never asserts `valid_o`, even if a sync stream is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided data clock, one nibble per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| nib_i | input | 4 | Four captured serial bits, lane order per R2 |
| train_req_i | input | 1 | One-cycle pulse that starts boundary training |
| word_o | output | 12 | Aligned sample word, MSB first |
| valid_o | output | 1 | One-cycle strobe marking a new `word_o` |
| locked_o | output | 1 | Boundary has been learned and frozen |
| off_o | output | 4 | Chosen bit offset, 0 to 11 |
| err_o | output | 1 | No sync match seen within the timeout |

## Verification
A train request and the output of a locked word can fall on the same frame-closing cycle. The bench steps the stream until the nibble count is 2 mod 3 and only then raises the request. It then requires that no valid appears at that edge, that lock drops at once, and that a fresh lock with the new offset follows. A second collision is a corrupted nibble landing in the middle of the eight-frame run. The bench judges that one by a lock that arrives later than the clean-stream bound but still at the correct offset.

// File: rtl/adc_align_pkg.sv
package adc_align_pkg;

  localparam int unsigned NIB_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRAIN = 2'd1,
    ST_LOCK  = 2'd2
  } align_st_e;

  // Lane order to serial order: result[3] is the earliest bit on the wire.
  function automatic logic [NIB_W-1:0] nib_to_serial(logic [NIB_W-1:0] n);
    return {n[0], n[2], n[1], n[3]};
  endfunction

endpackage

// File: rtl/adc_bit_window.sv
module adc_bit_window
  import adc_align_pkg::*;
#(
  parameter int unsigned WORD_W = 12,
  localparam int unsigned WIN_W = 2 * WORD_W,
  localparam int unsigned PER   = WORD_W / NIB_W,
  localparam int unsigned PH_W  = (PER > 1) ? $clog2(PER) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIB_W-1:0] nib_i,
  output logic [WIN_W-1:0] win_o,
  output logic             tick_o
);

  logic [WIN_W-1:0] hist_q;
  logic [PH_W-1:0]  ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_q <= '0;
      ph_q   <= '0;
    end else begin
      hist_q <= {hist_q[WIN_W-NIB_W-1:0], nib_to_serial(nib_i)};
      if (ph_q == PH_W'(PER - 1)) ph_q <= '0;
      else                        ph_q <= ph_q + PH_W'(1);
    end
  end

  assign win_o  = hist_q;
  assign tick_o = (ph_q == PH_W'(PER - 1));

endmodule

// File: rtl/adc_sync_search.sv
module adc_sync_search #(
  parameter int unsigned WORD_W = 12,
  parameter logic [WORD_W-1:0] SYNC_PAT = 12'hFC0,
  localparam int unsigned WIN_W = 2 * WORD_W,
  localparam int unsigned OFS_W = $clog2(WORD_W)
) (
  input  logic [WIN_W-1:0] win_i,
  output logic             hit_o,
  output logic [OFS_W-1:0] ofs_o
);

  logic [WORD_W-1:0] hits;

  for (genvar k = 0; k < WORD_W; k++) begin : g_cand
    assign hits[k] = (win_i[k +: WORD_W] == SYNC_PAT);
  end

  always_comb begin
    hit_o = |hits;
    ofs_o = '0;
    for (int k = WORD_W - 1; k >= 0; k--) begin
      if (hits[k]) ofs_o = OFS_W'(k);
    end
  end

endmodule

// File: rtl/adc_train_ctrl.sv
module adc_train_ctrl
  import adc_align_pkg::*;
#(
  parameter int unsigned OFS_W    = 4,
  parameter int unsigned LOCK_CNT = 8,
  parameter int unsigned TIMEOUT  = 256,
  localparam int unsigned CNT_W = $clog2(LOCK_CNT + 1),
  localparam int unsigned TMR_W = $clog2(TIMEOUT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             train_req_i,
  input  logic             tick_i,
  input  logic             hit_i,
  input  logic [OFS_W-1:0] hit_ofs_i,
  output logic             locked_o,
  output logic [OFS_W-1:0] ofs_o,
  output logic             err_o,
  output logic             lock_evt_o
);

  align_st_e        st_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [OFS_W-1:0] cand_q, ofs_q;
  logic [TMR_W-1:0] tmr_q;
  logic             seen_q, err_q;
  logic             same_ofs, frame_hit;

  assign frame_hit  = (st_q == ST_TRAIN) && tick_i && hit_i;
  assign same_ofs   = (cnt_q != '0) && (hit_ofs_i == cand_q);
  assign cnt_nxt    = same_ofs ? cnt_q + CNT_W'(1) : CNT_W'(1);
  assign lock_evt_o = frame_hit && (cnt_nxt == CNT_W'(LOCK_CNT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      cand_q <= '0;
      ofs_q  <= '0;
      tmr_q  <= '0;
      seen_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (train_req_i) begin
      st_q   <= ST_TRAIN;
      cnt_q  <= '0;
      tmr_q  <= '0;
      seen_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (st_q == ST_TRAIN) begin
      if (!seen_q && tmr_q != TMR_W'(TIMEOUT)) tmr_q <= tmr_q + TMR_W'(1);
      if (!seen_q && !frame_hit && tmr_q == TMR_W'(TIMEOUT - 1)) err_q <= 1'b1;
      if (tick_i) begin
        if (hit_i) begin
          seen_q <= 1'b1;
          cand_q <= hit_ofs_i;
          cnt_q  <= cnt_nxt;
          if (lock_evt_o) begin
            st_q  <= ST_LOCK;
            ofs_q <= hit_ofs_i;
            err_q <= 1'b0;
          end
        end else begin
          cnt_q <= '0;
        end
      end
    end
  end

  assign locked_o = (st_q == ST_LOCK);
  assign ofs_o    = ofs_q;
  assign err_o    = err_q;

endmodule

// File: rtl/adc_word_aligner.sv
module adc_word_aligner
  import adc_align_pkg::*;
#(
  parameter int unsigned WORD_W = 12,
  parameter logic [WORD_W-1:0] SYNC_PAT = 12'hFC0,
  parameter int unsigned LOCK_CNT = 8,
  parameter int unsigned TIMEOUT  = 256,
  localparam int unsigned WIN_W = 2 * WORD_W,
  localparam int unsigned OFS_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  nib_i,
  input  logic              train_req_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              locked_o,
  output logic [OFS_W-1:0]  off_o,
  output logic              err_o
);

  function automatic logic [WORD_W-1:0] pick_word(logic [WIN_W-1:0] w,
                                                   logic [OFS_W-1:0] k);
    logic [WIN_W-1:0] sh;
    sh = w >> k;
    return sh[WORD_W-1:0];
  endfunction

  logic [WIN_W-1:0] win;
  logic             frame_tick;
  logic             sync_hit;
  logic [OFS_W-1:0] sync_ofs;
  logic             lock_evt;
  logic             emit;
  logic [WORD_W-1:0] word_q;
  logic             valid_q;

  adc_bit_window #(.WORD_W(WORD_W)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .nib_i  (nib_i),
    .win_o  (win),
    .tick_o (frame_tick)
  );

  adc_sync_search #(.WORD_W(WORD_W), .SYNC_PAT(SYNC_PAT)) u_search (
    .win_i (win),
    .hit_o (sync_hit),
    .ofs_o (sync_ofs)
  );

  adc_train_ctrl #(.OFS_W(OFS_W), .LOCK_CNT(LOCK_CNT), .TIMEOUT(TIMEOUT)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .train_req_i (train_req_i),
    .tick_i      (frame_tick),
    .hit_i       (sync_hit),
    .hit_ofs_i   (sync_ofs),
    .locked_o    (locked_o),
    .ofs_o       (off_o),
    .err_o       (err_o),
    .lock_evt_o  (lock_evt)
  );

  assign emit = locked_o && frame_tick && !train_req_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= emit;
      if (emit) word_q <= pick_word(win, off_o);
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;

endmodule

// File: rtl/adc_word_aligner_chk.sv
module adc_word_aligner_chk #(
  parameter int unsigned OFS_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             train_req_i,
  input logic             valid_o,
  input logic             locked_o,
  input logic [OFS_W-1:0] off_o,
  input logic             err_o,
  input logic             frame_tick,
  input logic             lock_evt
);

  AST_VALID_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> locked_o); // R6
  AST_VALID_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R6
  AST_VALID_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(frame_tick)); // R6
  AST_OFFSET_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && $past(locked_o)) |-> $stable(off_o)); // R5
  AST_LOCK_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> $past(frame_tick && lock_evt)); // R4
  AST_REQ_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    train_req_i |=> (!locked_o && !valid_o)); // R8
  AST_ERR_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !locked_o); // R7

endmodule

bind adc_word_aligner adc_word_aligner_chk #(.OFS_W(OFS_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .train_req_i (train_req_i),
  .valid_o     (valid_o),
  .locked_o    (locked_o),
  .off_o       (off_o),
  .err_o       (err_o),
  .frame_tick  (frame_tick),
  .lock_evt    (lock_evt)
);

// File: tb/adc_word_aligner_tb.sv
module adc_word_aligner_tb;

  localparam logic [11:0] SYNC = 12'hFC0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  nib = '0;
  logic        req = 1'b0;
  logic [11:0] word_o;
  logic        valid_o, locked_o, err_o;
  logic [3:0]  off_o;

  int n_chk = 0, n_fail = 0;
  int ecnt = 0, scnt = 0, bk = 0;
  logic [63:0] hm = '0, hm_prev = '0;
  logic prev_lock = 1'b0, mon_en = 1'b0;

  always #5 clk = ~clk;

  adc_word_aligner u_dut (
    .clk(clk), .rst_n(rst_n), .nib_i(nib), .train_req_i(req),
    .word_o(word_o), .valid_o(valid_o), .locked_o(locked_o),
    .off_o(off_o), .err_o(err_o)
  );

  function automatic logic [3:0] to_nib(logic [3:0] b);
    return {b[0], b[2], b[1], b[3]}; // b[3] earliest -> lane 0 (R2)
  endfunction

  function automatic logic pat_bit(int i, int s);
    return SYNC[11 - ((i + s) % 12)];
  endfunction

  function automatic logic [3:0] pat4(int s);
    return {pat_bit(scnt, s), pat_bit(scnt + 1, s), pat_bit(scnt + 2, s), pat_bit(scnt + 3, s)};
  endfunction

  function automatic int exp_ofs(int s);
    return (s + 8) % 12;
  endfunction

  function automatic logic [11:0] exp_word(logic [63:0] h, int k);
    return 12'(h >> k);
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] b, input logic r);
    logic ev;
    nib = to_nib(b);
    req = r;
    @(posedge clk);
    ecnt++;
    scnt += 4;
    hm_prev = hm;
    hm = {hm[59:0], b};
    @(negedge clk);
    req = 1'b0;
    ev = prev_lock && (ecnt % 3 == 0) && !r;
    check(valid_o == ev, "R6", "valid cadence", int'(valid_o), int'(ev));
    if (valid_o && ev && mon_en)
      check(word_o == exp_word(hm_prev, bk), "R6", "aligned word",
            int'(word_o), int'(exp_word(hm_prev, bk)));
    prev_lock = locked_o;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; nib = '0; req = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    ecnt = 0; scnt = 0; hm = '0; hm_prev = '0; prev_lock = 1'b0; mon_en = 1'b0;
  endtask

  task automatic lock_on(input int s, input int maxc, output int at);
    at = -1;
    for (int i = 0; i < maxc; i++) begin
      step(pat4(s), 1'b0);
      if (locked_o && at < 0) begin
        at = ecnt; bk = exp_ofs(s); mon_en = 1'b1;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int r, at;
    void'($urandom(32'd20240607));

    // R1: reset state
    do_reset();
    check(word_o == 12'h0 && !valid_o && !locked_o && !err_o && off_o == 4'd0,
          "R1", "reset outputs", int'({word_o, valid_o, locked_o, err_o, off_o}), 0);

    // R9: sync present but no request
    repeat (20) step(pat4(3), 1'b0);
    check(!locked_o, "R9", "idle without request", int'(locked_o), 0);

    // R4/R3: clean lock latency and offset
    r = ecnt + 1;
    step(pat4(3), 1'b1);
    lock_on(3, 40, at);
    check(at >= r + 22 && at <= r + 24, "R4", "lock edge", at - r, 22);
    check(off_o == 4'(exp_ofs(3)), "R3", "offset s=3", int'(off_o), exp_ofs(3));
    for (int i = 0; i < 30; i++) begin
      step(pat4(3), 1'b0);
      if (valid_o) check(word_o == SYNC, "R2", "sync word", int'(word_o), int'(SYNC));
    end

    // R5/R6: random normal data after lock
    repeat (300) step(4'($urandom), 1'b0);
    check(locked_o && off_o == 4'(exp_ofs(3)), "R5", "offset after random",
          int'(off_o), exp_ofs(3));

    // R5: stream shifted while locked, slicing must not follow
    repeat (30) step(pat4(7), 1'b0);
    check(off_o == 4'(exp_ofs(3)), "R5", "offset after shift", int'(off_o), exp_ofs(3));

    // R8: train request on a frame-closing cycle
    while (ecnt % 3 != 2) step(pat4(7), 1'b0);
    step(pat4(7), 1'b1);
    check(!locked_o && !valid_o, "R8", "request on frame",
          int'({locked_o, valid_o}), 0);
    lock_on(7, 40, at);
    check(at > 0 && off_o == 4'(exp_ofs(7)), "R8", "relock offset", int'(off_o), exp_ofs(7));
    for (int i = 0; i < 30; i++) begin
      step(pat4(7), 1'b0);
      if (valid_o) check(word_o == SYNC, "R2", "sync word relock", int'(word_o), int'(SYNC));
    end

    // R4: corrupted nibble in the middle of training
    do_reset();
    repeat (8) step(pat4(0), 1'b0);
    r = ecnt + 1;
    step(pat4(0), 1'b1);
    at = -1;
    for (int i = 0; i < 50; i++) begin
      logic [3:0] b;
      b = pat4(0);
      if (i == 10) b = ~b;
      step(b, 1'b0);
      if (locked_o && at < 0) begin at = ecnt; bk = exp_ofs(0); mon_en = 1'b1; end
    end
    check(at > r + 24, "R4", "late lock after mismatch", at - r, 25);
    check(off_o == 4'(exp_ofs(0)), "R4", "offset after mismatch", int'(off_o), exp_ofs(0));

    // R7: timeout with no match
    do_reset();
    repeat (8) step(4'h0, 1'b0);
    r = ecnt + 1;
    step(4'h0, 1'b1);
    while (ecnt < r + 255) step(4'h0, 1'b0);
    check(!err_o, "R7", "err before timeout", int'(err_o), 0);
    step(4'h0, 1'b0);
    check(err_o && !locked_o, "R7", "err at timeout", int'(err_o), 1);
    step(pat4(5), 1'b1);
    check(!err_o, "R7", "err cleared by request", int'(err_o), 0);
    lock_on(5, 50, at);
    check(at > 0 && off_o == 4'(exp_ofs(5)) && !err_o, "R7", "lock after error",
          int'(off_o), exp_ofs(5));

    // R3: every alignment
    for (int s = 0; s < 12; s++) begin
      do_reset();
      repeat (8) step(pat4(s), 1'b0);
      step(pat4(s), 1'b1);
      lock_on(s, 30, at);
      check(at > 0 && off_o == 4'(exp_ofs(s)), "R3", "offset sweep", int'(off_o), exp_ofs(s));
      repeat (6) step(4'($urandom), 1'b0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule